// File: doc/BRIEF.md
# Operand-Selecting ALU Stage

This block is the arithmetic front end of a small 8-bit datapath. Two four-way operand selectors pick the ALU inputs. The A side takes constant zero, constant one, the external Q register value or the block's own accumulator. The B side takes constant zero, constant one, the external M register value or an external data bus. A 3-bit opcode chooses one of eight functions: three arithmetic and five logic.

The result and the four status flags are combinational. They are valid in the same cycle as the selects, the opcode and the operands. The accumulator captures the result on a rising clock edge when the load control is high. An active-low asynchronous reset clears the accumulator and takes priority over load. Feeding the accumulator back on the A side allows chains of operations across cycles.

The subtract functions follow the two's-complement adder convention. The subtrahend is inverted, and the carry-in acts as a "no borrow" input. Carry-out is therefore 1 when no borrow occurs.

Top module: `alu_stage`

## Requirements
- R1: The A-side operand is chosen by `a_sel_i` with this encoding: 0 gives 0x00, 1 gives 0x01, 2 gives `q_i` and 3 gives the accumulator value `acc_o`.
- R2: The B-side operand is chosen by `b_sel_i` with this encoding: 0 gives 0x00, 1 gives 0x01, 2 gives `m_i` and 3 gives `ext_i`.
- R3: The arithmetic opcodes produce these results modulo 256: 0 gives A+B+ci, 1 gives A−B−(1−ci) and 2 gives B−A−(1−ci).
- R4: The logic opcodes produce these results: 3 gives A|B, 4 gives A&B, 5 gives (~A)&B, 6 gives A^B and 7 gives ~(A^B).
- R5: For opcodes 0 to 2, `carry_o` is bit 8 of the 9-bit sum of the first operand, the second operand (inverted for the subtrahend) and ci. For opcodes 3 to 7, `carry_o` is 0 whatever ci is.
- R6: For opcodes 0 to 2, `ovf_o` is 1 exactly when the signed result does not fit in 8 bits. For opcodes 3 to 7, `ovf_o` is 0.
- R7: For every opcode, `zero_o` is 1 exactly when `result_o` is 0x00, and `neg_o` equals `result_o[7]`.
- R8: On a rising clock edge with `load_i`=1 and reset released, `acc_o` takes the value `result_o` had before the edge.
- R9: With `load_i`=0, `acc_o` keeps its value across clock edges, even while the selects, opcode and operands change.
- R10: While `rst_ni` is low, `acc_o` is 0x00, even when `load_i` is 1 on a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_sel_i | input | 2 | A-side operand select |
| b_sel_i | input | 2 | B-side operand select |
| op_i | input | 3 | ALU function code |
| carry_i | input | 1 | Carry-in / no-borrow for arithmetic |
| load_i | input | 1 | Accumulator load enable |
| q_i | input | 8 | Q register value |
| m_i | input | 8 | M register value |
| ext_i | input | 8 | External data bus |
| result_o | output | 8 | ALU result |
| acc_o | output | 8 | Accumulator value |
| carry_o | output | 1 | Carry-out flag |
| ovf_o | output | 1 | Signed overflow flag |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |

## Verification
The bench targets the subtract carry convention in both directions, with and without borrow. A design that treated carry-out as a raw borrow would report the inverted flag. Overflow is driven at the signed limits 0x7F+1 and 0x80−1, and also on operands of opposite sign that cannot overflow. A design that took overflow from only one carry, or from the sign of the result alone, fails one of these cases. Logic functions run with carry-in set, so a leaked adder carry or overflow becomes visible. A sweep of all sixteen selector pairs with a loaded accumulator catches swapped mux legs. Reset is asserted while load is high, so a design that let load win would show a nonzero accumulator.

// File: rtl/alu_stage_pkg.sv
package alu_stage_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_RSUB = 3'd2,
    OP_OR   = 3'd3,
    OP_AND  = 3'd4,
    OP_ANDN = 3'd5,
    OP_XOR  = 3'd6,
    OP_XNOR = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_ONE  = 2'd1,
    SEL_REG  = 2'd2,
    SEL_AUX  = 2'd3
  } opnd_sel_e;

endpackage

// File: rtl/operand_mux.sv
module operand_mux
  import alu_stage_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [1:0]   sel_i,
  input  logic [W-1:0] reg_i,
  input  logic [W-1:0] aux_i,
  output logic [W-1:0] opnd_o
);

  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    unique case (opnd_sel_e'(sel_i))
      SEL_ZERO: opnd_o = '0;
      SEL_ONE:  opnd_o = ONE;
      SEL_REG:  opnd_o = reg_i;
      default:  opnd_o = aux_i;
    endcase
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_stage_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  input  logic         carry_i,
  output logic [W-1:0] f_o,
  output logic         co_o,
  output logic         ovf_o,
  output logic         n_o,
  output logic         z_o
);

  localparam int unsigned MSB = W - 1;

  alu_op_e      op;
  logic [W-1:0] add_x, add_y, lo_sum, arith;
  logic [1:0]   hi_sum;
  logic         c_into_msb, c_out, is_arith;

  assign op = alu_op_e'(op_i);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_RSUB);

  // subtrahend inverted, carry-in doubles as no-borrow
  always_comb begin
    unique case (op)
      OP_SUB:  begin add_x = a_i;  add_y = ~b_i; end
      OP_RSUB: begin add_x = b_i;  add_y = ~a_i; end
      default: begin add_x = a_i;  add_y = b_i;  end
    endcase
  end

  // split adder exposes the carry into the msb for overflow
  assign lo_sum     = {1'b0, add_x[MSB-1:0]} + {1'b0, add_y[MSB-1:0]}
                    + {{(W-1){1'b0}}, carry_i};
  assign c_into_msb = lo_sum[MSB];
  assign hi_sum     = {1'b0, add_x[MSB]} + {1'b0, add_y[MSB]} + {1'b0, c_into_msb};
  assign c_out      = hi_sum[1];
  assign arith      = {hi_sum[0], lo_sum[MSB-1:0]};

  always_comb begin
    unique case (op)
      OP_OR:   f_o = a_i | b_i;
      OP_AND:  f_o = a_i & b_i;
      OP_ANDN: f_o = ~a_i & b_i;
      OP_XOR:  f_o = a_i ^ b_i;
      OP_XNOR: f_o = ~(a_i ^ b_i);
      default: f_o = arith;
    endcase
  end

  assign co_o  = is_arith & c_out;
  assign ovf_o = is_arith & (c_out ^ c_into_msb);
  assign n_o   = f_o[MSB];
  assign z_o   = (f_o == '0);

endmodule

// File: rtl/acc_reg.sv
module acc_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

endmodule

// File: rtl/alu_stage.sv
module alu_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   a_sel_i,
  input  logic [1:0]   b_sel_i,
  input  logic [2:0]   op_i,
  input  logic         carry_i,
  input  logic         load_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] m_i,
  input  logic [W-1:0] ext_i,
  output logic [W-1:0] result_o,
  output logic [W-1:0] acc_o,
  output logic         carry_o,
  output logic         ovf_o,
  output logic         neg_o,
  output logic         zero_o
);

  logic [W-1:0] opnd_a, opnd_b;

  operand_mux #(.W(W)) u_mux_a (
    .sel_i  (a_sel_i),
    .reg_i  (q_i),
    .aux_i  (acc_o),
    .opnd_o (opnd_a)
  );

  operand_mux #(.W(W)) u_mux_b (
    .sel_i  (b_sel_i),
    .reg_i  (m_i),
    .aux_i  (ext_i),
    .opnd_o (opnd_b)
  );

  alu_core #(.W(W)) u_alu (
    .a_i     (opnd_a),
    .b_i     (opnd_b),
    .op_i    (op_i),
    .carry_i (carry_i),
    .f_o     (result_o),
    .co_o    (carry_o),
    .ovf_o   (ovf_o),
    .n_o     (neg_o),
    .z_o     (zero_o)
  );

  acc_reg #(.W(W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .d_i    (result_o),
    .q_o    (acc_o)
  );

endmodule

// File: rtl/alu_stage_chk.sv
module alu_stage_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [1:0]   a_sel_i,
  input logic [1:0]   b_sel_i,
  input logic [2:0]   op_i,
  input logic         carry_i,
  input logic         load_i,
  input logic [W-1:0] result_o,
  input logic [W-1:0] acc_o,
  input logic         carry_o,
  input logic         ovf_o,
  input logic         neg_o,
  input logic         zero_o
);

  // R1 R2
  const_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_sel_i == 2'd1 && b_sel_i == 2'd1 && op_i == 3'd0 && !carry_i)
      |-> (result_o == W'(2)));

  // R5
  logic_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 3'd3) |-> !carry_o);

  // R6
  logic_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 3'd3) |-> !ovf_o);

  // R7
  zero_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> (!neg_o && result_o == '0));

  // R8
  acc_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (acc_o == $past(result_o)));

  // R9
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(acc_o));

  // R10
  acc_reset_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (acc_o == '0));

endmodule

bind alu_stage alu_stage_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_sel_i  (a_sel_i),
  .b_sel_i  (b_sel_i),
  .op_i     (op_i),
  .carry_i  (carry_i),
  .load_i   (load_i),
  .result_o (result_o),
  .acc_o    (acc_o),
  .carry_o  (carry_o),
  .ovf_o    (ovf_o),
  .neg_o    (neg_o),
  .zero_o   (zero_o)
);

// File: tb/alu_stage_bench.sv
module alu_stage_bench;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] a_sel_i = '0, b_sel_i = '0;
  logic [2:0] op_i = '0;
  logic       carry_i = 1'b0, load_i = 1'b0;
  logic [7:0] q_i = '0, m_i = '0, ext_i = '0;
  logic [7:0] result_o, acc_o;
  logic       carry_o, ovf_o, neg_o, zero_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] acc_exp = '0;

  always #4 clk_i = ~clk_i;

  alu_stage u_alu_stage (
    .clk_i, .rst_ni, .a_sel_i, .b_sel_i, .op_i, .carry_i, .load_i,
    .q_i, .m_i, .ext_i, .result_o, .acc_o, .carry_o, .ovf_o, .neg_o, .zero_o
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pick_a(logic [1:0] s);
    case (s)
      2'd0: return 8'h00;
      2'd1: return 8'h01;
      2'd2: return q_i;
      default: return acc_exp;
    endcase
  endfunction

  function automatic logic [7:0] pick_b(logic [1:0] s);
    case (s)
      2'd0: return 8'h00;
      2'd1: return 8'h01;
      2'd2: return m_i;
      default: return ext_i;
    endcase
  endfunction

  // drive, then compare result and all flags against an independent model
  task automatic run_op(string req, logic [2:0] op, logic [1:0] as, logic [1:0] bs, logic ci);
    logic [7:0] a, b, f;
    logic [8:0] s;
    logic co, ov;
    @(negedge clk_i);
    op_i = op; a_sel_i = as; b_sel_i = bs; carry_i = ci;
    #1;
    a = pick_a(as); b = pick_b(bs); co = 0; ov = 0;
    case (op)
      3'd0: begin s = a + b + ci;  ov = (a[7] == b[7]) && (s[7] != a[7]); end
      3'd1: begin s = a + {1'b0, ~b} + ci; ov = (a[7] != b[7]) && (s[7] != a[7]); end
      3'd2: begin s = b + {1'b0, ~a} + ci; ov = (a[7] != b[7]) && (s[7] != b[7]); end
      default: s = '0;
    endcase
    case (op)
      3'd3: f = a | b;
      3'd4: f = a & b;
      3'd5: f = ~a & b;
      3'd6: f = a ^ b;
      3'd7: f = ~(a ^ b);
      default: begin f = s[7:0]; co = s[8]; end
    endcase
    chk(req, "result", result_o, f);
    chk("R5", "carry", carry_o, co);
    chk("R6", "ovf", ovf_o, ov);
    chk("R7", "zero", zero_o, f == 0);
    chk("R7", "neg", neg_o, f[7]);
  endtask

  task automatic load_acc(logic [7:0] v);
    @(negedge clk_i);
    ext_i = v; a_sel_i = 2'd0; b_sel_i = 2'd3; op_i = 3'd3; load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
    acc_exp = v;
    #1;
    chk("R8", "acc load", acc_o, v);
  endtask

  task automatic t_reset();
    #1;
    chk("R10", "acc at reset", acc_o, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_arith();
    q_i = 8'd14; m_i = 8'd6;
    run_op("R3", 3'd0, 2'd2, 2'd2, 1'b0);      // 14+6
    run_op("R3", 3'd1, 2'd2, 2'd2, 1'b1);      // 14-6, no borrow -> co=1
    run_op("R3", 3'd2, 2'd2, 2'd2, 1'b1);      // 6-14, borrow
    run_op("R3", 3'd1, 2'd2, 2'd2, 1'b0);      // 14-6-1
    q_i = 8'h7F; m_i = 8'h01;
    run_op("R6", 3'd0, 2'd2, 2'd2, 1'b0);      // positive overflow
    q_i = 8'hFF;
    run_op("R5", 3'd0, 2'd2, 2'd2, 1'b0);      // wraps to zero, co=1
    q_i = 8'h80;
    run_op("R6", 3'd1, 2'd2, 2'd2, 1'b1);      // negative overflow
    q_i = 8'hF2; m_i = 8'h06;
    run_op("R6", 3'd0, 2'd2, 2'd2, 1'b1);      // mixed sign, no overflow
    run_op("R3", 3'd2, 2'd2, 2'd2, 1'b1);
    q_i = 8'h05; m_i = 8'h05;
    run_op("R7", 3'd1, 2'd2, 2'd2, 1'b1);      // equal -> zero
  endtask

  task automatic t_logic();
    q_i = 8'hF0; m_i = 8'h3C;
    for (int op = 3; op < 8; op++) run_op("R4", 3'(op), 2'd2, 2'd2, 1'b1);
    q_i = 8'hFF; m_i = 8'hFF;
    run_op("R4", 3'd6, 2'd2, 2'd2, 1'b1);      // xor to zero
    run_op("R4", 3'd5, 2'd2, 2'd2, 1'b1);
  endtask

  task automatic t_sel();
    q_i = 8'h21; m_i = 8'h40; ext_i = 8'h08;
    load_acc(8'h90);
    ext_i = 8'h08;
    for (int as = 0; as < 4; as++)
      for (int bs = 0; bs < 4; bs++)
        run_op("R1 R2", 3'd3, 2'(as), 2'(bs), 1'b0);
  endtask

  task automatic t_acc();
    q_i = 8'h33; m_i = 8'h44;
    @(negedge clk_i);
    a_sel_i = 2'd2; b_sel_i = 2'd2; op_i = 3'd0; carry_i = 1'b0; load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0; acc_exp = 8'h77; #1;
    chk("R8", "acc after add", acc_o, 8'h77);
    // accumulate: acc + 1 twice
    @(negedge clk_i);
    a_sel_i = 2'd3; b_sel_i = 2'd1; load_i = 1'b1;
    repeat (2) @(negedge clk_i);
    load_i = 1'b0; acc_exp = 8'h79; #1;
    chk("R8", "acc feedback", acc_o, 8'h79);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      op_i = 3'(k + 4); q_i = q_i + 8'h11; ext_i = 8'(k);
      @(negedge clk_i); #1;
      chk("R9", "acc hold", acc_o, 8'h79);
    end
  endtask

  task automatic t_reset_prio();
    @(negedge clk_i);
    a_sel_i = 2'd1; b_sel_i = 2'd1; op_i = 3'd0; load_i = 1'b1;
    rst_ni = 1'b0; #1;
    chk("R10", "async clear", acc_o, 0);
    @(posedge clk_i); #1;
    chk("R10", "reset over load", acc_o, 0);
    @(negedge clk_i);
    load_i = 1'b0; rst_ni = 1'b1; acc_exp = 8'h00; #1;
    chk("R10", "after reset", acc_o, 0);
  endtask

  initial begin
    t_reset();
    t_arith();
    t_logic();
    t_sel();
    t_acc();
    t_reset_prio();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule